// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block is a synchronous front end for an external asynchronous static RAM with a 17-bit address, a byte-wide data bus, two chip-select pins of opposite polarity, an output enable and a write enable. A host hands it one word at a time over a valid/ready port. Each accepted request is turned into a complete pin-level read or write cycle. The controller counts system-clock cycles so that every nanosecond minimum of the RAM is met.

The timing minimums are given as parameters in nanoseconds, together with the clock period. Each one is turned into a cycle count by rounding up, with a floor of one cycle. The data bus is split into an output value, an output-enable and an input value, so a pad ring can build the tri-state buffer. The controller decides when that buffer may drive. After every read it waits out the RAM's output-float time. Between requests the chip is deselected and held in standby.

With the default 8 ns clock, a read keeps the chip selected for 7 cycles and is followed by 3 turnaround cycles. A write holds WE low for 6 cycles and then holds the data for 1 more cycle, 7 cycles in total.

Top module: `asram_ctl`

## Requirements
- R1: While reset is asserted and whenever the controller is idle, ram_sel_n=1, ram_sel=0, ram_oe_n=1, ram_we_n=1 and ram_dq_oe=0, so the chip is deselected and in standby.
- R2: req_ready is 1 only when idle. A request is taken on a rising edge where req_valid and req_ready are both 1; req_write=1 selects a write and req_write=0 a read. While busy, a held req_valid is not taken.
- R3: A read keeps the chip selected (ram_sel_n=0, ram_sel=1) with ram_oe_n=0, ram_we_n=1 and ram_dq_oe=0 for RD cycles, starting in the cycle after acceptance. RD is the largest of ceil(read cycle/clk), ceil(access/clk) and ceil(OE access/clk); it is 7 by default.
- R4: The byte on ram_dq_in in the last cycle of a read is presented on rsp_rdata, with rsp_valid high for exactly one cycle: the cycle right after the last read cycle.
- R5: After each read, the chip stays deselected and req_ready stays 0 for HZ = ceil(float time/clk) cycles (3 by default) before the next request can be taken.
- R6: A write keeps the chip selected with ram_we_n=0, ram_oe_n=1, ram_dq_oe=1 and ram_dq_out equal to the accepted data for WP cycles. WP is the largest of the rounded write-pulse, address-to-end and data-setup minimums; it is 6 by default.
- R7: After WE rises, the chip stays selected and the data stays driven for exactly one hold cycle. ram_dq_oe then drops. Deselected recovery cycles follow so that the write spans at least ceil(write cycle/clk) cycles in total, which is 7 by default and needs 0 extra cycles.
- R8: ram_addr and ram_dq_out hold the values taken at acceptance for the whole access. Changes on req_addr, req_wdata, req_write or req_valid while busy do not reach the pins.
- R9: ram_dq_oe is never 1 while ram_oe_n=0, and ram_we_n is low only while the chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 17 | RAM address pins |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_out | output | 8 | Data value to drive onto the RAM bus |
| ram_dq_oe | output | 1 | Data bus driver enable |
| ram_dq_in | input | 8 | Data value sampled from the RAM bus |

## Verification
The bench runs four kinds of traffic: a single write followed by a read-back, back-to-back reads, writes directly after reads, and reads directly after writes. Read-after-write separates a correct bus release from a driver held too long. Write-after-read is where a missing float gap shows up, as an early req_ready. The bench's RAM model only puts valid data on ram_dq_in in the final read cycle, so sampling one cycle early returns a garbage byte. Request inputs are scrambled while the controller is busy, and the extreme addresses 0 and 1FFFF are used to catch stale or corrupted address and data registers.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_GAP,
        ST_WRITE,
        ST_HOLD
    } st_e;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_ctl_timer.sv
module asram_ctl_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3: a freshly loaded non-zero count cannot read as expired.
    a_r3_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/asram_ctl_fsm.sv
module asram_ctl_fsm
    import asram_ctl_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 8,
    parameter int CW      = 3,
    parameter int RD_CYC  = 7,
    parameter int WE_CYC  = 6,
    parameter int HZ_CYC  = 3,
    parameter int REC_CYC = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic [AW-1:0] ram_addr,
    output logic          ram_sel_n,
    output logic          ram_sel,
    output logic          ram_oe_n,
    output logic          ram_we_n,
    output logic [DW-1:0] ram_dq_out,
    output logic          ram_dq_oe,
    input  logic [DW-1:0] ram_dq_in
);

    localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WE_LD  = CW'(WE_CYC - 1);
    localparam logic [CW-1:0] HZ_LD  = CW'(HZ_CYC - 1);
    localparam logic [CW-1:0] REC_LD = CW'((REC_CYC > 0) ? REC_CYC - 1 : 0);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          sel_n;
        logic          sel;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
        logic          rsp_valid;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.sel_n = 1'b0;
                    r_d.sel   = 1'b1;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.st    = ST_WRITE;
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        tmr_val   = WE_LD;
                    end else begin
                        r_d.st   = ST_READ;
                        r_d.oe_n = 1'b0;
                        tmr_val  = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    r_d.rdata     = ram_dq_in;
                    r_d.rsp_valid = 1'b1;
                    r_d.sel_n     = 1'b1;
                    r_d.sel       = 1'b0;
                    r_d.oe_n      = 1'b1;
                    r_d.st        = ST_GAP;
                    tmr_load      = 1'b1;
                    tmr_val       = HZ_LD;
                end
            end
            ST_GAP: begin
                if (tmr_expired) r_d.st = ST_IDLE;
            end
            ST_WRITE: begin
                if (tmr_expired) begin
                    r_d.we_n = 1'b1;
                    r_d.st   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                r_d.dq_oe = 1'b0;
                r_d.sel_n = 1'b1;
                r_d.sel   = 1'b0;
                if (REC_CYC > 0) begin
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.sel_n <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_rdata  = r_q.rdata;
    assign ram_addr   = r_q.addr;
    assign ram_sel_n  = r_q.sel_n;
    assign ram_sel    = r_q.sel;
    assign ram_oe_n   = r_q.oe_n;
    assign ram_we_n   = r_q.we_n;
    assign ram_dq_out = r_q.wdata;
    assign ram_dq_oe  = r_q.dq_oe;

    logic chip_on;
    assign chip_on = !ram_sel_n && ram_sel;

    // R1: idle means standby pins.
    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_sel_n && !ram_sel && ram_oe_n && ram_we_n && !ram_dq_oe));

    // R4: read data strobe lasts one cycle.
    a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: the end of a read output enable is never followed straight by readiness.
    a_r5_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> !req_ready);

    // R6: write enable falls together with the data driver turning on.
    a_r6_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> ram_dq_oe);

    // R8: address holds while the chip stays selected.
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_on && $past(chip_on)) |-> $stable(ram_addr));

    // R9: no bus fight and no unselected write strobe.
    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);
    a_r9_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (chip_on && ram_oe_n));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 8,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 25,
    parameter int T_WP_NS = 40,
    parameter int T_AW_NS = 45,
    parameter int T_DW_NS = 20,
    parameter int T_WC_NS = 55,
    parameter int T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int RD_CYC  = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                  ns2cyc(T_OE_NS, CLK_NS));
    localparam int WE_CYC  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                  ns2cyc(T_DW_NS, CLK_NS));
    localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
    localparam int HZ_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int REC_CYC = (WC_CYC > WE_CYC + 1) ? (WC_CYC - WE_CYC - 1) : 0;
    localparam int CNT_MAX = imax(imax(RD_CYC, WE_CYC), imax(HZ_CYC, imax(REC_CYC, 1)));
    localparam int CW      = imax($clog2(CNT_MAX + 1), 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    asram_ctl_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_ctl_fsm #(
        .AW      (ADDR_W),
        .DW      (DATA_W),
        .CW      (CW),
        .RD_CYC  (RD_CYC),
        .WE_CYC  (WE_CYC),
        .HZ_CYC  (HZ_CYC),
        .REC_CYC (REC_CYC)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ram_addr    (ram_addr),
        .ram_sel_n   (ram_sel_n),
        .ram_sel     (ram_sel),
        .ram_oe_n    (ram_oe_n),
        .ram_we_n    (ram_we_n),
        .ram_dq_out  (ram_dq_out),
        .ram_dq_oe   (ram_dq_oe),
        .ram_dq_in   (ram_dq_in)
    );

endmodule

// File: tb/asram_ctl_tb_top.sv
module asram_ctl_tb_top;

    localparam int CLK_NS = 8;
    // Cycle counts worked out from the requirements for the default minimums.
    localparam int RD = (55 + CLK_NS - 1) / CLK_NS;   // 7
    localparam int WP = (45 + CLK_NS - 1) / CLK_NS;   // 6
    localparam int HZ = (20 + CLK_NS - 1) / CLK_NS;   // 3
    localparam int WC = (55 + CLK_NS - 1) / CLK_NS;   // 7
    localparam int WEND = (WC > WP + 1) ? WC : WP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] ram_addr;
    logic        ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in = 8'hEE;

    always #(CLK_NS / 2) clk = ~clk;

    asram_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    int n_checks = 0;
    int n_errors = 0;

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model (behavioural) ----------------
    int          m_mode = 0;        // 0 idle, 1 read, 2 write
    int          m_t = 0;
    logic [16:0] m_addr;
    logic [7:0]  m_data;
    logic [7:0]  ref_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            m_t = 0;
        end else if (m_mode == 0) begin
            if (req_valid) begin
                m_mode = req_write ? 2 : 1;
                m_t    = 1;
                m_addr = req_addr;
                m_data = req_wdata;
                if (req_write) ref_mem[int'(req_addr)] = req_wdata;
            end
        end else begin
            m_t++;
            if (m_mode == 1 && m_t > RD + HZ) m_mode = 0;
            if (m_mode == 2 && m_t > WEND) m_mode = 0;
        end
    end

    // ---------------- RAM pin model ----------------
    logic [7:0]  ram_mem [int];
    int          rd_age = 0;
    bit          wr_pend = 0;
    logic [16:0] wr_a;
    logic [7:0]  wr_d;

    always @(negedge clk) begin
        bit sel;
        sel = !ram_sel_n && ram_sel;
        if (sel && !ram_oe_n && ram_we_n) rd_age++;
        else rd_age = 0;
        if (sel && !ram_we_n && ram_dq_oe) begin
            wr_pend = 1; wr_a = ram_addr; wr_d = ram_dq_out;
        end else if (wr_pend && ram_we_n) begin
            ram_mem[int'(wr_a)] = wr_d;
            wr_pend = 0;
        end
        if (rd_age == RD)
            ram_dq_in = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : dflt(ram_addr);
        else
            ram_dq_in = 8'hEE;
    end

    // ---------------- per-cycle comparison ----------------
    logic [7:0] exp_rd;
    always @(negedge clk) begin
        logic [5:0] exp_pins, act_pins;
        string tag;
        bit sel_exp, chk_addr, chk_data, exp_rsp;
        sel_exp = 0; chk_addr = 0; chk_data = 0; exp_rsp = 0;
        exp_pins = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}; // sel_n sel oe_n we_n dq_oe ready
        tag = "R1 standby";
        if (m_mode == 1) begin
            if (m_t <= RD) begin
                exp_pins = 6'b010100; tag = "R3 read pins"; chk_addr = 1;
            end else begin
                exp_pins = 6'b101100; tag = "R5 float gap";
                exp_rsp = (m_t == RD + 1);
            end
        end else if (m_mode == 2) begin
            if (m_t <= WP) begin
                exp_pins = 6'b011010; tag = "R6 write pulse"; chk_addr = 1; chk_data = 1;
            end else if (m_t == WP + 1) begin
                exp_pins = 6'b011110; tag = "R7 write hold"; chk_addr = 1; chk_data = 1;
            end else begin
                exp_pins = 6'b101100; tag = "R7 recovery";
            end
        end else if (rst_n) begin
            tag = "R2 idle ready";
        end
        act_pins = {ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe, req_ready};
        check(act_pins === exp_pins, tag, 32'(act_pins), 32'(exp_pins));
        if (chk_addr)
            check(ram_addr === m_addr, "R8 address held", 32'(ram_addr), 32'(m_addr));
        if (chk_data)
            check(ram_dq_out === m_data, "R8 write data held", 32'(ram_dq_out), 32'(m_data));
        check(rsp_valid === exp_rsp, "R4 rsp_valid pulse", 32'(rsp_valid), 32'(exp_rsp));
        if (exp_rsp) begin
            exp_rd = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : dflt(m_addr);
            check(rsp_rdata === exp_rd, "R4 read data", 32'(rsp_rdata), 32'(exp_rd));
        end
        check(!(ram_dq_oe && !ram_oe_n) && (ram_we_n || (!ram_sel_n && ram_sel)),
              "R9 bus safety", 32'(act_pins), 32'(exp_pins));
    end

    // ---------------- stimulus ----------------
    task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // R8: scramble the host inputs while the access runs.
        req_valid = 1'b0;
        req_write = ~wr;
        req_addr  = ~a;
        req_wdata = ~d;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 R4: single write then read back
        do_req(1, 17'h12345, 8'hA5);
        do_req(0, 17'h12345, 8'h00);
        // boundary addresses and data values
        do_req(1, 17'h00000, 8'h00);
        do_req(1, 17'h1FFFF, 8'hFF);
        do_req(0, 17'h1FFFF, 8'h11);
        do_req(0, 17'h00000, 8'h22);
        // R5: write directly after a read
        do_req(0, 17'h00010, 8'h00);
        do_req(1, 17'h00010, 8'h3C);
        do_req(0, 17'h00010, 8'h00);
        // R2: valid held high across a busy access (back-to-back reads)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h12345;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_addr = 17'h1FFFF;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        // mixed traffic on a small address window
        for (int i = 0; i < 40; i++) begin
            logic [16:0] a;
            a = 17'h08000 + 17'($urandom_range(0, 15));
            do_req(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
        end
        wait_idle();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule